// File: doc/BRIEF.md
# Hex Record Loader

This block takes a stream of ASCII characters, one per accepted strobe, and interprets it as a sequence of hexadecimal load records of the kind used to move machine code into program memory. Each record opens with a colon and carries a byte count, a 16-bit load address, a record type, the data bytes and a checksum. Every field is written as pairs of ASCII hex digits. The block converts the digits to bytes and steps through the fields. For every data byte it issues one write on a simple memory port. It also keeps a running sum, so the checksum is judged the moment its last digit arrives.

The block sits between a character source, such as a UART receiver or a boot ROM streamer, and a code memory. It raises a sticky error flag for malformed or corrupt records and then resynchronises on the next colon. It raises a sticky done flag once a final record with a correct checksum has been seen. From that point it stops accepting characters until reset.

Top module: `hexrec_loader`

## Requirements
- R1: After reset memWe, errFlag and doneFlag are 0 and chReady is 1.
- R2: Outside a record, every character other than a colon (0x3A) is ignored, including carriage return (0x0D) and line feed (0x0A): no write happens and no flag changes.
- R3: A colon starts a record whose fields follow in this order: count (1 byte), address (2 bytes, high byte first), type (1 byte), data (count bytes), checksum (1 byte). Each byte is two ASCII hex digits, high nibble first. Digits 0-9, A-F and a-f are all accepted.
- R4: Data byte i of a record is written to (load address + i) modulo 2^16. memWe is high for exactly the one cycle after the clock edge that accepts that byte's second digit, with memAddr and memData valid in that cycle.
- R5: A record with count 00 produces no write.
- R6: A count above 10h sets errFlag when its second digit is accepted. The rest of that record produces no write, and the parser waits for the next colon.
- R7: Any character that is not a hex digit (a colon included) arriving after a record's colon and before its checksum is complete sets errFlag, abandons the record, and makes the parser wait for the next colon.
- R8: A record is good when the low byte of the sum of all its bytes, checksum included, is 00h. Otherwise errFlag is set in the cycle after the checksum's second digit is accepted. Data bytes are written as they arrive, so a corrupt record's data has already been written by then.
- R9: A type value other than 00h (data) or 01h (end of file) sets errFlag, and the record produces no write.
- R10: A type-01h record with a good checksum raises doneFlag and drops chReady in the cycle after its last checksum digit is accepted. A type-01h record with a bad checksum leaves doneFlag at 0.
- R11: errFlag and doneFlag stay set until reset. While doneFlag is high, input characters have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| chValid | input | 1 | Character strobe from the source |
| chData | input | 8 | ASCII character |
| chReady | output | 1 | A character is taken on an edge where chValid and chReady are both high |
| memWe | output | 1 | One-cycle write strobe for a data byte |
| memAddr | output | 16 | Write address |
| memData | output | 8 | Write data |
| errFlag | output | 1 | Sticky error: bad character, count, type or checksum |
| doneFlag | output | 1 | Sticky: a good end-of-file record has been seen |

## Verification
All results come from one register stage behind the accepting clock edge. A data write is due in the cycle after the edge that takes that byte's low digit. The error and done flags are due in the cycle after the edge that takes the offending character or the checksum's low digit. The bench drives each character from one falling edge to the next. It samples the outputs on the falling edge that ends that character, which falls inside the cycle where the result is due. A falling-edge monitor logs every write strobe. The log is then compared, entry for entry, with a list the bench builds arithmetically from the record it sent.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [7:0] CH_COLON = 8'h3A;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_ADDRH,
    ST_ADDRL,
    ST_TYPE,
    ST_DATA,
    ST_CSUM,
    ST_EOF
  } parseState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic takeHi;
    logic clrSum;
    logic addSum;
    logic ldCount;
    logic ldAddrHi;
    logic ldAddrLo;
    logic ldType;
    logic wrData;
    logic setErr;
    logic setDone;
  } ctrlStrobes_t;

endpackage

// File: rtl/hexrec_dpath.sv
module hexrec_dpath
  import hexrec_pkg::*;
#(
  parameter int REM_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           chData,
  input  ctrlStrobes_t         strb,
  output logic                 isHex,
  output logic                 isColon,
  output logic [BYTE_W-1:0]    curByte,
  output logic [BYTE_W-1:0]    sumWithByte,
  output logic [REM_W-1:0]     remain,
  output logic                 isEof,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [BYTE_W-1:0]    memData,
  output logic                 errFlag,
  output logic                 doneFlag
);

  logic [3:0]        nibVal;
  logic [3:0]        hiNib;
  logic [BYTE_W-1:0] sumAcc;
  logic [ADDR_W-1:0] addrPtr;

  // ASCII hex digit decode, both letter cases
  always_comb begin
    isHex  = 1'b1;
    nibVal = 4'h0;
    if (chData >= 8'h30 && chData <= 8'h39) begin
      nibVal = chData[3:0];
    end else if ((chData >= 8'h41 && chData <= 8'h46) ||
                 (chData >= 8'h61 && chData <= 8'h66)) begin
      nibVal = chData[3:0] + 4'd9;
    end else begin
      isHex = 1'b0;
    end
  end

  assign isColon     = (chData == CH_COLON);
  assign curByte     = {hiNib, nibVal};
  assign sumWithByte = sumAcc + curByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiNib    <= '0;
      sumAcc   <= '0;
      addrPtr  <= '0;
      remain   <= '0;
      isEof    <= 1'b0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
      errFlag  <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      memWe <= 1'b0;
      if (strb.takeHi) hiNib <= nibVal;
      if (strb.clrSum) sumAcc <= '0;
      else if (strb.addSum) sumAcc <= sumWithByte;
      if (strb.ldCount) remain <= curByte[REM_W-1:0];
      if (strb.ldAddrHi) addrPtr[ADDR_W-1:8] <= curByte;
      if (strb.ldAddrLo) addrPtr[7:0] <= curByte;
      if (strb.ldType) isEof <= curByte[0];
      if (strb.wrData) begin
        memWe   <= 1'b1;
        memAddr <= addrPtr;
        memData <= curByte;
        addrPtr <= addrPtr + 1'b1;
        remain  <= remain - 1'b1;
      end
      if (strb.setErr) errFlag <= 1'b1;
      if (strb.setDone) doneFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/hexrec_ctrl.sv
module hexrec_ctrl
  import hexrec_pkg::*;
#(
  parameter int MAX_COUNT = 16,
  parameter int REM_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chValid,
  input  logic              isHex,
  input  logic              isColon,
  input  logic [BYTE_W-1:0] curByte,
  input  logic [BYTE_W-1:0] sumWithByte,
  input  logic [REM_W-1:0]  remain,
  input  logic              isEof,
  output logic              chReady,
  output ctrlStrobes_t      strb
);

  localparam logic [BYTE_W-1:0] COUNT_LIMIT = BYTE_W'(MAX_COUNT);
  localparam logic [REM_W-1:0]  REM_ONE     = REM_W'(1);

  parseState_t st, stNext;
  logic        wantHi, wantHiNext;
  logic        accept;

  assign chReady = (st != ST_EOF);
  assign accept  = chValid && chReady;

  always_comb begin
    strb       = '0;
    stNext     = st;
    wantHiNext = wantHi;
    case (st)
      ST_IDLE: begin
        if (accept && isColon) begin
          stNext      = ST_COUNT;
          wantHiNext  = 1'b1;
          strb.clrSum = 1'b1;
        end
      end
      ST_EOF: ;
      default: begin
        if (accept) begin
          if (!isHex) begin
            strb.setErr = 1'b1;
            stNext      = ST_IDLE;
          end else if (wantHi) begin
            strb.takeHi = 1'b1;
            wantHiNext  = 1'b0;
          end else begin
            wantHiNext  = 1'b1;
            strb.addSum = 1'b1;
            case (st)
              ST_COUNT: begin
                if (curByte > COUNT_LIMIT) begin
                  strb.setErr = 1'b1;
                  stNext      = ST_IDLE;
                end else begin
                  strb.ldCount = 1'b1;
                  stNext       = ST_ADDRH;
                end
              end
              ST_ADDRH: begin
                strb.ldAddrHi = 1'b1;
                stNext        = ST_ADDRL;
              end
              ST_ADDRL: begin
                strb.ldAddrLo = 1'b1;
                stNext        = ST_TYPE;
              end
              ST_TYPE: begin
                if (curByte > 8'h01) begin
                  strb.setErr = 1'b1;
                  stNext      = ST_IDLE;
                end else begin
                  strb.ldType = 1'b1;
                  stNext      = (remain == '0) ? ST_CSUM : ST_DATA;
                end
              end
              ST_DATA: begin
                strb.wrData = 1'b1;
                if (remain == REM_ONE) stNext = ST_CSUM;
              end
              ST_CSUM: begin
                if (sumWithByte != '0) begin
                  strb.setErr = 1'b1;
                  stNext      = ST_IDLE;
                end else if (isEof) begin
                  strb.setDone = 1'b1;
                  stNext       = ST_EOF;
                end else begin
                  stNext = ST_IDLE;
                end
              end
              default: stNext = ST_IDLE;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      wantHi <= 1'b1;
    end else begin
      st     <= stNext;
      wantHi <= wantHiNext;
    end
  end

endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
  import hexrec_pkg::*;
#(
  parameter int MAX_COUNT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chValid,
  input  logic [7:0]  chData,
  output logic        chReady,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [7:0]  memData,
  output logic        errFlag,
  output logic        doneFlag
);

  localparam int REM_W = $clog2(MAX_COUNT + 1);

  ctrlStrobes_t      strb;
  logic              isHex;
  logic              isColon;
  logic [BYTE_W-1:0] curByte;
  logic [BYTE_W-1:0] sumWithByte;
  logic [REM_W-1:0]  remain;
  logic              isEof;

  hexrec_ctrl #(
    .MAX_COUNT(MAX_COUNT),
    .REM_W    (REM_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chValid    (chValid),
    .isHex      (isHex),
    .isColon    (isColon),
    .curByte    (curByte),
    .sumWithByte(sumWithByte),
    .remain     (remain),
    .isEof      (isEof),
    .chReady    (chReady),
    .strb       (strb)
  );

  hexrec_dpath #(
    .REM_W(REM_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .chData     (chData),
    .strb       (strb),
    .isHex      (isHex),
    .isColon    (isColon),
    .curByte    (curByte),
    .sumWithByte(sumWithByte),
    .remain     (remain),
    .isEof      (isEof),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memData    (memData),
    .errFlag    (errFlag),
    .doneFlag   (doneFlag)
  );

endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk (
  input logic clk,
  input logic rstN,
  input logic chValid,
  input logic chReady,
  input logic memWe,
  input logic errFlag,
  input logic doneFlag
);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> doneFlag);

  // R10
  ready_low_when_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !chReady);

  // R4
  write_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R4
  write_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(chValid && chReady));

  // R10
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(chValid && chReady));

  // R10
  done_not_with_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !$rose(errFlag));

endmodule

bind hexrec_loader hexrec_loader_chk u_loader_chk (
  .clk     (clk),
  .rstN    (rstN),
  .chValid (chValid),
  .chReady (chReady),
  .memWe   (memWe),
  .errFlag (errFlag),
  .doneFlag(doneFlag)
);

// File: tb/test_hexrec_loader.sv
module test_hexrec_loader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chValid = 1'b0;
  logic [7:0]  chData = 8'h00;
  logic        chReady;
  logic        memWe;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic        errFlag;
  logic        doneFlag;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [15:0] expA[$];
  logic [7:0]  expD[$];
  logic [15:0] capA[$];
  logic [7:0]  capD[$];

  always #10 clk = ~clk;

  hexrec_loader i_hexrec_loader (
    .clk(clk), .rstN(rstN), .chValid(chValid), .chData(chData),
    .chReady(chReady), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .errFlag(errFlag), .doneFlag(doneFlag)
  );

  always @(negedge clk) begin
    if (rstN && memWe) begin
      capA.push_back(memAddr);
      capD.push_back(memData);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkFlags(input string req, input bit e, input bit d, input bit r);
    check(errFlag == e, {req, " errFlag"}, errFlag, e);
    check(doneFlag == d, {req, " doneFlag"}, doneFlag, d);
    check(chReady == r, {req, " chReady"}, chReady, r);
  endtask

  task automatic compareWrites(input string req);
    check(capA.size() == expA.size(), {req, " write count"}, capA.size(), expA.size());
    if (capA.size() == expA.size()) begin
      for (int i = 0; i < expA.size(); i++) begin
        check(capA[i] == expA[i], {req, " write addr"}, capA[i], expA[i]);
        check(capD[i] == expD[i], {req, " write data"}, capD[i], expD[i]);
      end
    end
    capA.delete(); capD.delete(); expA.delete(); expD.delete();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    chValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    capA.delete(); capD.delete(); expA.delete(); expD.delete();
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic sendChar(input logic [7:0] c);
    chData = c;
    chValid = 1'b1;
    @(negedge clk);
    chValid = 1'b0;
  endtask

  function automatic logic [7:0] hexCh(input logic [3:0] n, input bit lower);
    if (n < 4'd10) return 8'h30 + 8'(n);
    return (lower ? 8'h61 : 8'h41) + 8'(n - 4'd10);
  endfunction

  task automatic sendByte(input logic [7:0] b, input bit lower);
    sendChar(hexCh(b[7:4], lower));
    sendChar(hexCh(b[3:0], lower));
  endtask

  function automatic logic [7:0] dataOf(input int seed, input int i);
    return 8'((seed * 7 + i * 29 + 3) & 255);
  endfunction

  task automatic sendRecord(input int cnt, input logic [15:0] addr, input logic [7:0] typ,
                            input int seed, input bit lower, input bit badSum,
                            input bit expectWr);
    logic [7:0] sum;
    logic [7:0] csum;
    sum = 8'(cnt) + addr[15:8] + addr[7:0] + typ;
    for (int i = 0; i < cnt; i++) sum += dataOf(seed, i);
    csum = 8'h00 - sum;
    if (badSum) csum = csum ^ 8'h01;
    sendChar(8'h3A);
    sendByte(8'(cnt), lower);
    sendByte(addr[15:8], lower);
    sendByte(addr[7:0], lower);
    sendByte(typ, lower);
    for (int i = 0; i < cnt; i++) begin
      sendByte(dataOf(seed, i), lower);
      if (expectWr) begin
        expA.push_back(addr + 16'(i));
        expD.push_back(dataOf(seed, i));
      end
    end
    sendByte(csum, lower);
  endtask

  initial begin
    doReset();
    // R1 reset state
    check(memWe == 1'b0, "R1 memWe", memWe, 0);
    checkFlags("R1", 1'b0, 1'b0, 1'b1);

    // R2 junk between records is ignored
    sendChar(8'h0D); sendChar(8'h0A); sendChar("x"); sendChar("4"); sendChar(" ");
    compareWrites("R2 junk");
    checkFlags("R2", 1'b0, 1'b0, 1'b1);

    // R3 R4 R5 R8 sweep every legal count, both letter cases, address wrap at 16
    for (int cnt = 0; cnt <= 16; cnt++) begin
      logic [15:0] a;
      a = (cnt == 16) ? 16'hFFF8 : 16'(cnt * 16'h0913 + 16'h00AF);
      sendRecord(cnt, a, 8'h00, cnt + 1, cnt[0], 1'b0, 1'b1);
      sendChar(8'h0D); sendChar(8'h0A);
      compareWrites(cnt == 0 ? "R5 empty record" : "R4 R3 data record");
      checkFlags("R8 good sum", 1'b0, 1'b0, 1'b1);
    end

    // R6 count too large, then resync on the next colon
    doReset();
    sendRecord(17, 16'h2000, 8'h00, 5, 1'b0, 1'b0, 1'b0);
    compareWrites("R6 oversize count");
    checkFlags("R6", 1'b1, 1'b0, 1'b1);
    sendRecord(3, 16'h3000, 8'h00, 9, 1'b1, 1'b0, 1'b1);
    compareWrites("R6 resync");
    checkFlags("R11 err sticky", 1'b1, 1'b0, 1'b1);

    // R7 non-hex in address field, and a colon in mid-record
    doReset();
    sendChar(8'h3A); sendByte(8'h02, 1'b0); sendChar("1"); sendChar("G");
    checkFlags("R7 bad char", 1'b1, 1'b0, 1'b1);
    sendByte(8'h00, 1'b0); sendByte(8'h00, 1'b0);
    compareWrites("R7 abandoned");
    sendRecord(2, 16'h4010, 8'h00, 11, 1'b0, 1'b0, 1'b1);
    compareWrites("R7 resync");
    doReset();
    sendChar(8'h3A); sendByte(8'h01, 1'b0); sendChar(8'h3A);
    checkFlags("R7 colon inside", 1'b1, 1'b0, 1'b1);

    // R8 bad checksum: data already written, error after last digit
    doReset();
    sendRecord(4, 16'h5000, 8'h00, 13, 1'b0, 1'b1, 1'b1);
    compareWrites("R8 bad sum writes");
    checkFlags("R8 bad sum", 1'b1, 1'b0, 1'b1);

    // R9 unsupported type
    doReset();
    sendRecord(2, 16'h6000, 8'h02, 3, 1'b0, 1'b0, 1'b0);
    compareWrites("R9 bad type");
    checkFlags("R9", 1'b1, 1'b0, 1'b1);

    // R10 end record with bad checksum
    doReset();
    sendRecord(0, 16'h0000, 8'h01, 0, 1'b0, 1'b1, 1'b0);
    checkFlags("R10 bad eof", 1'b1, 1'b0, 1'b1);

    // R10 R11 good end record, later input ignored
    doReset();
    sendRecord(1, 16'h7000, 8'h00, 2, 1'b0, 1'b0, 1'b1);
    compareWrites("R10 pre data");
    sendRecord(0, 16'h0000, 8'h01, 0, 1'b0, 1'b0, 1'b0);
    checkFlags("R10 eof", 1'b0, 1'b1, 1'b0);
    sendChar(8'h3A); sendChar("0"); sendChar("1"); sendChar("G");
    repeat (4) @(negedge clk);
    compareWrites("R11 after done");
    checkFlags("R11 after done", 1'b0, 1'b1, 1'b0);

    summary();
  end

endmodule